// File: doc/BRIEF.md
# Frame-Sync Serial Slave (8/16-bit)

This block is the slave end of a synchronous serial link that uses framing driven by a sync pulse. An external master supplies the serial clock, a one-period frame-sync pulse and the master-to-slave data line. The block answers on the slave-to-master data line and drives that line only while its own data bits are on the wire. The serial inputs are oversampled in the block's system clock domain. Frames are 8 or 16 bits long, most significant bit first. Both the launch and capture edges are fixed by the frame format.

On the parallel side there is a single transmit holding register and a single receive holding register. Each has a simple flag: transmit-empty and receive-valid. Two sticky error flags report problems. The first is a sync pulse that lands inside a frame; that frame is aborted. The second is a frame that began with no transmit word loaded; that frame sends all ones. A single status-read strobe clears both flags. Sync pulses may overlap the last bit of a frame, so frames can follow each other with no idle period between them.

Top module: `ti_ssp_slave`

## Requirements
- R1: A frame starts when `fss_i` is sampled high on a falling edge of `sck_i` while the slave is idle. On the next rising edge the slave puts out its first bit. Each of the following falling edges captures `mosi_i`, MSB first. Frame length is 8 bits when `wide_i`=0 and 16 bits when `wide_i`=1. `wide_i` is latched when the frame starts, so later changes do not affect that frame.
- R2: When the last bit has been captured, the received word is placed on `rx_data_o` and `rx_valid_o` is set. For 8-bit frames the word sits in bits [7:0] and bits [15:8] are zero. `rx_valid_o` and `rx_data_o` hold until `rx_ack_i` is pulsed or the next frame completes.
- R3: `miso_oe_o` is high only from the rising edge that launches the first bit up to the falling edge that captures the last bit. At all other times, including reset and idle, it is low.
- R4: `miso_o` shifts out the transmit word MSB first. For 8-bit frames the bits sent are `tx_data_i[7:0]`.
- R5: A `tx_load_i` pulse stores `tx_data_i` and drives `tx_empty_o` low. When a frame starts, it takes the stored word and `tx_empty_o` goes high again.
- R6: If a frame starts while `tx_empty_o` is high, the frame sends all ones and `underrun_o` is set. `underrun_o` stays set until a `status_rd_i` pulse.
- R7: If `fss_i` is sampled high on a falling edge inside a frame other than at the last bit, `fpulse_err_o` is set and the frame is aborted. An aborted frame does not raise `rx_valid_o`, and `miso_oe_o` goes low. The pulse that caused the error does not start a frame; the next pulse sampled while idle does.
- R8: `fpulse_err_o` is sticky. A `status_rd_i` pulse clears it, unless a new error occurs in the same cycle.
- R9: If `fss_i` is sampled high on the falling edge that captures the last bit, a new frame starts at the next rising edge with no idle period, and no error is flagged.
- R10: The inputs `cfg_pol_i`, `cfg_pha_i` and `cfg_cs_sw_i` have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial lines |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_pol_i | input | 1 | Clock polarity setting, ignored by the fixed format |
| cfg_pha_i | input | 1 | Clock phase setting, ignored by the fixed format |
| cfg_cs_sw_i | input | 1 | Chip-select software/output control, ignored |
| wide_i | input | 1 | Frame length: 0 = 8 bits, 1 = 16 bits |
| sck_i | input | 1 | Serial clock from the master |
| fss_i | input | 1 | Frame sync pulse from the master |
| mosi_i | input | 1 | Data from master to slave |
| miso_o | output | 1 | Data from slave to master |
| miso_oe_o | output | 1 | Output enable for miso_o; low means the line floats |
| tx_data_i | input | 16 | Transmit word |
| tx_load_i | input | 1 | Strobe that stores tx_data_i |
| tx_empty_o | output | 1 | Transmit holding register is empty |
| rx_data_o | output | 16 | Last received word |
| rx_valid_o | output | 1 | Received word is waiting |
| rx_ack_i | input | 1 | Strobe that clears rx_valid_o |
| status_rd_i | input | 1 | Status read strobe; clears both error flags |
| fpulse_err_o | output | 1 | A sync pulse arrived inside a frame |
| underrun_o | output | 1 | A frame started with no transmit word loaded |

## Verification
Frames are run with random payloads in both directions. The stimulus mixes 8-bit and 16-bit lengths, frames with a loaded word and frames with none, and isolated frames alongside chains of frames started by a sync pulse on the last bit. Comparing the two lengths shows whether the bit count and the low-bit alignment are right. Comparing loaded and empty starts separates a real payload from the all-ones fill. Chains show whether a pulse on the last bit is taken as the start of a new frame rather than as an error. `wide_i` and the ignored configuration inputs are changed at random partway through frames. A directed case then puts a sync pulse in the middle of a frame and checks three things: the frame is dropped, the line floats, and the next pulse brings the slave back into step.

// File: rtl/ti_ssp_pkg.sv
package ti_ssp_pkg;
  localparam int unsigned DEF_DATA_W   = 16;
  localparam int unsigned DEF_NARROW_W = 8;
  localparam int unsigned DEF_SYNC     = 2;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_SHIFT = 2'd2
  } ssp_state_e;
endpackage

// File: rtl/ti_ssp_sync.sv
module ti_ssp_sync #(
  parameter int unsigned W      = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] pipe_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) pipe_q[s] <= '0;
        else if (s == 0) pipe_q[s] <= d_i;
        else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/ti_ssp_engine.sv
module ti_ssp_engine
  import ti_ssp_pkg::*;
#(
  parameter int unsigned DATA_W   = DEF_DATA_W,
  parameter int unsigned NARROW_W = DEF_NARROW_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_rise_i,
  input  logic              sck_fall_i,
  input  logic              fss_i,
  input  logic              mosi_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] tx_word_i,
  input  logic              tx_have_i,
  output logic              take_o,
  output logic              uflow_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_word_o,
  output logic              perr_o,
  output logic              wide_q_o,
  output logic              miso_o,
  output logic              miso_oe_o
);
  localparam int unsigned CNT_W   = $clog2(DATA_W);
  localparam int unsigned SHIFT_N = DATA_W - NARROW_W;
  localparam logic [DATA_W-1:0] NARROW_MASK = {{SHIFT_N{1'b0}}, {NARROW_W{1'b1}}};

  ssp_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              wide_q;
  logic [DATA_W-1:0] tx_sh_q, rx_sh_q, rx_next;
  logic              last_bit, fall_in_frame;

  assign last_bit      = wide_q ? (cnt_q == CNT_W'(DATA_W-1)) : (cnt_q == CNT_W'(NARROW_W-1));
  assign fall_in_frame = (state_q == ST_SHIFT) && sck_fall_i;
  assign take_o        = (state_q == ST_ARMED) && sck_rise_i;
  assign uflow_o       = take_o && !tx_have_i;
  assign done_o        = fall_in_frame && last_bit;
  assign perr_o        = fall_in_frame && !last_bit && fss_i;
  assign rx_next       = {rx_sh_q[DATA_W-2:0], mosi_i};
  assign rx_word_o     = wide_q ? rx_next : (rx_next & NARROW_MASK);
  assign wide_q_o      = wide_q;
  assign miso_o        = tx_sh_q[DATA_W-1];
  assign miso_oe_o     = (state_q == ST_SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wide_q  <= 1'b0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (sck_fall_i && fss_i) state_q <= ST_ARMED;
        ST_ARMED: if (sck_rise_i) begin
          state_q <= ST_SHIFT;
          cnt_q   <= '0;
          wide_q  <= wide_i;
          if (!tx_have_i)  tx_sh_q <= '1;              // underrun fill
          else if (wide_i) tx_sh_q <= tx_word_i;
          else             tx_sh_q <= tx_word_i << SHIFT_N; // left-align narrow word
        end
        ST_SHIFT: begin
          if (sck_rise_i) tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b1};
          if (sck_fall_i) begin
            rx_sh_q <= rx_next;
            cnt_q   <= cnt_q + CNT_W'(1);
            if (last_bit) state_q <= fss_i ? ST_ARMED : ST_IDLE;
            else if (fss_i) state_q <= ST_IDLE;       // misplaced pulse: abort
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ti_ssp_regs.sv
module ti_ssp_regs #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_load_i,
  input  logic              take_i,
  output logic [DATA_W-1:0] tx_word_o,
  output logic              tx_full_o,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_word_i,
  input  logic              rx_ack_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              perr_i,
  input  logic              uflow_i,
  input  logic              status_rd_i,
  output logic              perr_o,
  output logic              uflow_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_word_o  <= '0;
      tx_full_o  <= 1'b0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
      perr_o     <= 1'b0;
      uflow_o    <= 1'b0;
    end else begin
      if (tx_load_i) begin
        tx_word_o <= tx_data_i;
        tx_full_o <= 1'b1;
      end else if (take_i) begin
        tx_full_o <= 1'b0;
      end
      if (done_i) begin
        rx_data_o  <= rx_word_i;
        rx_valid_o <= 1'b1;
      end else if (rx_ack_i) begin
        rx_valid_o <= 1'b0;
      end
      // set wins over clear
      if (perr_i) perr_o <= 1'b1;
      else if (status_rd_i) perr_o <= 1'b0;
      if (uflow_i) uflow_o <= 1'b1;
      else if (status_rd_i) uflow_o <= 1'b0;
    end
  end
endmodule

// File: rtl/ti_ssp_slave.sv
module ti_ssp_slave
  import ti_ssp_pkg::*;
#(
  parameter int unsigned DATA_W      = DEF_DATA_W,
  parameter int unsigned NARROW_W    = DEF_NARROW_W,
  parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_pol_i,
  input  logic              cfg_pha_i,
  input  logic              cfg_cs_sw_i,
  input  logic              wide_i,
  input  logic              sck_i,
  input  logic              fss_i,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe_o,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              tx_load_i,
  output logic              tx_empty_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_valid_o,
  input  logic              rx_ack_i,
  input  logic              status_rd_i,
  output logic              fpulse_err_o,
  output logic              underrun_o
);
  logic [2:0]        ser_s;
  logic              sck_s, fss_s, mosi_s, sck_d;
  logic              take, uflow_set, done, perr_set, wide_q, tx_full;
  logic [DATA_W-1:0] tx_word, rx_word;
  logic              unused_cfg;

  // format fixes polarity, phase and chip-select handling
  assign unused_cfg = cfg_pol_i ^ cfg_pha_i ^ cfg_cs_sw_i;

  ti_ssp_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({sck_i, fss_i, mosi_i}),
    .q_o   (ser_s)
  );
  assign {sck_s, fss_s, mosi_s} = ser_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_d <= 1'b0;
    else         sck_d <= sck_s;
  end

  ti_ssp_engine #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_eng (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .sck_rise_i(sck_s & ~sck_d),
    .sck_fall_i(~sck_s & sck_d),
    .fss_i     (fss_s),
    .mosi_i    (mosi_s),
    .wide_i    (wide_i),
    .tx_word_i (tx_word),
    .tx_have_i (tx_full),
    .take_o    (take),
    .uflow_o   (uflow_set),
    .done_o    (done),
    .rx_word_o (rx_word),
    .perr_o    (perr_set),
    .wide_q_o  (wide_q),
    .miso_o    (miso_o),
    .miso_oe_o (miso_oe_o)
  );

  ti_ssp_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tx_data_i  (tx_data_i),
    .tx_load_i  (tx_load_i),
    .take_i     (take),
    .tx_word_o  (tx_word),
    .tx_full_o  (tx_full),
    .done_i     (done),
    .rx_word_i  (rx_word),
    .rx_ack_i   (rx_ack_i),
    .rx_data_o  (rx_data_o),
    .rx_valid_o (rx_valid_o),
    .perr_i     (perr_set),
    .uflow_i    (uflow_set),
    .status_rd_i(status_rd_i),
    .perr_o     (fpulse_err_o),
    .uflow_o    (underrun_o)
  );

  assign tx_empty_o = ~tx_full;
endmodule

// File: rtl/ti_ssp_checker.sv
module ti_ssp_checker #(
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned NARROW_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              perr_set,
  input logic              done,
  input logic              take,
  input logic              wide_q,
  input logic              status_rd_i,
  input logic              fpulse_err_o,
  input logic              miso_oe_o,
  input logic              rx_valid_o,
  input logic              rx_ack_i,
  input logic [DATA_W-1:0] rx_data_o,
  input logic              tx_load_i,
  input logic              tx_empty_o
);
  p_err_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fpulse_err_o && !status_rd_i |=> fpulse_err_o);

  p_err_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_rd_i && !perr_set |=> !fpulse_err_o);

  p_abort_float_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    perr_set |=> !miso_oe_o && fpulse_err_o);

  p_rx_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o && !rx_ack_i && !done |=> rx_valid_o && $stable(rx_data_o));

  p_narrow_upper_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done && !wide_q |=> rx_data_o[DATA_W-1:NARROW_W] == '0);

  p_take_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take && !tx_load_i |=> tx_empty_o);

  p_load_full_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_i |=> !tx_empty_o);
endmodule

bind ti_ssp_slave ti_ssp_checker #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .perr_set    (perr_set),
  .done        (done),
  .take        (take),
  .wide_q      (wide_q),
  .status_rd_i (status_rd_i),
  .fpulse_err_o(fpulse_err_o),
  .miso_oe_o   (miso_oe_o),
  .rx_valid_o  (rx_valid_o),
  .rx_ack_i    (rx_ack_i),
  .rx_data_o   (rx_data_o),
  .tx_load_i   (tx_load_i),
  .tx_empty_o  (tx_empty_o)
);

// File: tb/sim_ti_ssp_slave.sv
`timescale 1ns/1ps
module sim_ti_ssp_slave;
  localparam int H  = 6;
  localparam int NF = 24;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_pol = 0, cfg_pha = 0, cfg_cs = 0, wide = 0;
  logic sck = 0, fss = 0, mosi = 0;
  logic miso, miso_oe, tx_empty, rx_valid, fperr, underrun;
  logic [15:0] tx_data = '0, rx_data;
  logic tx_load = 0, rx_ack = 0, status_rd = 0;
  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  ti_ssp_slave u0 (
    .clk_i(clk), .rst_ni(rst_n), .cfg_pol_i(cfg_pol), .cfg_pha_i(cfg_pha),
    .cfg_cs_sw_i(cfg_cs), .wide_i(wide), .sck_i(sck), .fss_i(fss), .mosi_i(mosi),
    .miso_o(miso), .miso_oe_o(miso_oe), .tx_data_i(tx_data), .tx_load_i(tx_load),
    .tx_empty_o(tx_empty), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .rx_ack_i(rx_ack), .status_rd_i(status_rd), .fpulse_err_o(fperr),
    .underrun_o(underrun)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rx(input bit w, input logic [15:0] mo);
    return w ? mo : {8'h00, mo[7:0]};
  endfunction

  function automatic logic [15:0] exp_tx(input bit w, input bit have, input logic [15:0] t);
    if (!have) return w ? 16'hffff : 16'h00ff;
    return w ? t : {8'h00, t[7:0]};
  endfunction

  task automatic strobe_ack();
    @(negedge clk) rx_ack = 1; @(negedge clk) rx_ack = 0;
  endtask
  task automatic strobe_status();
    @(negedge clk) status_rd = 1; @(negedge clk) status_rd = 0;
  endtask
  task automatic load(input logic [15:0] w);
    @(negedge clk) begin tx_data = w; tx_load = 1; end
    @(negedge clk) tx_load = 0;
  endtask

  // one serial clock period: rising at start, falling after H cycles
  task automatic period(input bit f, input bit m, output bit so, output bit soe);
    @(negedge clk) begin sck = 1; fss = f; mosi = m; end
    repeat (H) @(negedge clk);
    so = miso; soe = miso_oe;
    sck = 0;
    repeat (H) @(negedge clk);
  endtask

  task automatic frame(input bit w, input logic [15:0] mo, input bit last_f,
                       input bit nxt_ld, input logic [15:0] nxt_t, input bit nxt_w,
                       output logic [15:0] got, output bit oe_ok, output bit empty_first);
    int n = w ? 16 : 8;
    bit so, soe;
    got = '0; oe_ok = 1; empty_first = 0;
    for (int k = 0; k < n; k++) begin
      period((k == n-1) ? last_f : 1'b0, mo[n-1-k], so, soe);
      got = {got[14:0], so};
      if (!soe) oe_ok = 0;
      if (k == 0) begin
        empty_first = tx_empty;
        wide = nxt_w;                       // frame must keep its latched length
        {cfg_pol, cfg_pha, cfg_cs} = 3'($urandom);
        strobe_ack();
        if (nxt_ld) load(nxt_t);
      end
    end
    fss = 0;
  endtask

  initial begin
    bit so, soe, oe_ok, ef, chain, cur_w, cur_have, nxt_w, nxt_have, nxt_chain;
    logic [15:0] cur_t, nxt_t, mo, got;
    void'($urandom(32'd4711));
    repeat (8) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R3 reset oe", 16'(miso_oe), 16'h0);
    chk("R2 reset rx_valid", 16'(rx_valid), 16'h0);
    chk("R5 reset tx_empty", 16'(tx_empty), 16'h1);
    chk("R8 reset err", 16'(fperr), 16'h0);
    chk("R6 reset underrun", 16'(underrun), 16'h0);

    cur_w = 1; cur_t = 16'hc35a; cur_have = 1; chain = 0;
    wide = cur_w;
    load(cur_t);
    chk("R5 load clears empty", 16'(tx_empty), 16'h0);

    for (int i = 0; i < NF; i++) begin
      if (!chain) begin
        period(1'b1, 1'b0, so, soe);
        chk("R3 oe low during sync", 16'(soe), 16'h0);
      end
      mo        = 16'($urandom);
      nxt_w     = 1'($urandom);
      nxt_t     = 16'($urandom);
      nxt_have  = ($urandom % 4) != 0;
      nxt_chain = (i < NF-1) && (($urandom % 3) == 0);
      frame(cur_w, mo, nxt_chain, nxt_have, nxt_t, nxt_w, got, oe_ok, ef);
      chk("R4 miso word", got, exp_tx(cur_w, cur_have, cur_t));
      chk("R3 oe during data", 16'(oe_ok), 16'h1);
      chk("R5 taken at start", 16'(ef), 16'h1);
      chk(chain ? "R9 chained rx_valid" : "R2 rx_valid", 16'(rx_valid), 16'h1);
      chk("R1 R10 rx word", rx_data, exp_rx(cur_w, mo));
      chk("R6 underrun flag", 16'(underrun), 16'(!cur_have));
      chk("R9 no error", 16'(fperr), 16'h0);
      chk("R3 oe low after frame", 16'(miso_oe), 16'h0);
      chk("R5 empty reflects load", 16'(tx_empty), 16'(!nxt_have));
      strobe_status();
      chk("R6 underrun cleared", 16'(underrun), 16'h0);
      cur_w = nxt_w; cur_t = nxt_t; cur_have = nxt_have; chain = nxt_chain;
    end

    // directed: misplaced pulse in a narrow frame
    strobe_ack();
    wide = 0;
    load(16'h5aa5);
    period(1'b1, 1'b0, so, soe);
    for (int k = 0; k < 3; k++) period(1'b0, 1'b1, so, soe);
    period(1'b1, 1'b0, so, soe);
    chk("R7 err set", 16'(fperr), 16'h1);
    chk("R7 oe dropped", 16'(miso_oe), 16'h0);
    for (int k = 0; k < 5; k++) begin
      period(1'b0, 1'b1, so, soe);
      chk("R7 floats after abort", 16'(soe), 16'h0);
    end
    chk("R7 frame discarded", 16'(rx_valid), 16'h0);
    chk("R8 err still held", 16'(fperr), 16'h1);
    strobe_status();
    chk("R8 err cleared", 16'(fperr), 16'h0);

    // resync on next valid pulse
    load(16'h0096);
    period(1'b1, 1'b0, so, soe);
    frame(1'b0, 16'h003c, 1'b0, 1'b0, 16'h0, 1'b1, got, oe_ok, ef);
    chk("R7 resync rx", rx_data, 16'h003c);
    chk("R7 resync rx_valid", 16'(rx_valid), 16'h1);
    chk("R4 resync miso", got, 16'h0096);
    chk("R8 no new error", 16'(fperr), 16'h0);
    strobe_ack();
    chk("R2 ack clears valid", 16'(rx_valid), 16'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule